// File: doc/BRIEF.md
# Coprocessor Register Transfer Sequencer

This block carries out the two instructions that move a single 32-bit word between a core register and an attached coprocessor. It decodes the instruction word, tests its condition field against the current NZCV flags, and then runs a short handshake with the coprocessor. The coprocessor number, its opcode, both of its register numbers and the type field go out with the request. While the coprocessor reports busy, the sequencer waits. It then either writes the received word to the register file or sends a register value to the coprocessor.

Register 15 is handled differently in each direction. As a destination, only the top four bits of the received word are used, and they load the N, Z, C and V flags. As a source, the value sent is the captured PC plus 12. Each cycle of a transfer is labelled as sequential, internal or coprocessor-transfer, so the core's cycle accounting can follow it. If no coprocessor answers within a set number of cycles, the instruction is reported as undefined.

Top module: `cpxfer_seq`

## Requirements
- R1: Instruction fields are cond[31:28], bits 27:24 = 1110, opc[23:21], dir L[20], CRn[19:16], Rd[15:12], coprocessor number[11:8], type[7:5], bit 4 = 1, CRm[3:0]. While cp_req is high, cp_num, cp_opc, cp_crn, cp_crm, cp_type and cp_dir carry these fields and stay stable.
- R2: When the condition fails against flags_in (flags_in[3:2:1:0] = N,Z,C,V; for example, code 0000 passes only when Z=1), cp_req stays low, no register or flag write occurs, and done pulses in the cycle after start with undef low.
- R3: With L=1 and Rd other than 15, rf_we pulses exactly once, in the transfer cycle, with rf_wr_addr = Rd and rf_wr_data = cp_rdata.
- R4: With L=1 and Rd = 15, flag_we pulses once with flag_out = cp_rdata[31:28], and rf_we never rises.
- R5: With L=0 and Rd other than 15, rf_rd_addr = Rd, cp_wdata equals rf_rd_data in the transfer cycle, and neither rf_we nor flag_we rises.
- R6: With L=0 and Rd = 15, cp_wdata in the transfer cycle equals the pc_in captured at start plus 12.
- R7: With L=1 and a coprocessor that holds cp_busy for b request cycles, the sequencer produces one cycle of cyc_type 00 (sequential), then b+1 cycles of 01 (internal), then one cycle of 10 (transfer), with done high in the transfer cycle.
- R8: With L=0, the sequence is one 00 cycle, then b cycles of 01, then one 10 cycle, with done high in the 10 cycle.
- R9: If cp_ack stays low for TIMEOUT sequential cycles, undef and done pulse together in the next cycle, cp_req drops, and no register or flag write occurs.
- R10: A start with bits 27:24 not equal to 1110, or with bit 4 low, raises undef and done in the next cycle without any request.
- R11: Synchronous active-high reset leaves cp_req, rf_we, flag_we, done, undef and cyc_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Issue the instruction on instr (accepted only when idle) |
| instr | input | 32 | Instruction word |
| flags_in | input | 4 | Current N,Z,C,V flags |
| pc_in | input | 32 | PC value captured at start |
| rf_rd_addr | output | 4 | Register-file read address |
| rf_rd_data | input | 32 | Register-file read data |
| rf_we | output | 1 | Register-file write strobe |
| rf_wr_addr | output | 4 | Register-file write address |
| rf_wr_data | output | 32 | Register-file write data |
| flag_we | output | 1 | NZCV update strobe |
| flag_out | output | 4 | New N,Z,C,V values |
| cp_req | output | 1 | Coprocessor request, held for the whole transfer |
| cp_dir | output | 1 | Direction: 1 = coprocessor to core |
| cp_num | output | 4 | Coprocessor number |
| cp_opc | output | 3 | Coprocessor opcode |
| cp_crn | output | 4 | Coprocessor register CRn |
| cp_crm | output | 4 | Coprocessor register CRm |
| cp_type | output | 3 | Type field |
| cp_wdata | output | 32 | Word sent to the coprocessor |
| cp_ack | input | 1 | Coprocessor accepts the request |
| cp_busy | input | 1 | Coprocessor still working |
| cp_rdata | input | 32 | Word returned by the coprocessor |
| cyc_valid | output | 1 | cyc_type is meaningful this cycle |
| cyc_type | output | 2 | 00 sequential, 01 internal, 10 transfer |
| done | output | 1 | Last cycle of the instruction |
| undef | output | 1 | Undefined-instruction outcome |

## Verification
On every cycle, the assertions check these properties: a transfer starts with a sequential cycle and ends with the request dropping after the transfer cycle; register and flag writes never coincide; an undefined outcome never carries a write or a request; the request fields stay stable while the request is held; and a coprocessor-to-core transfer is always preceded by an internal cycle. The bench scenarios are the only way to show the exact counts of internal cycles for a given busy length, the data values (PC plus 12, the top-nibble flag load), the condition-failure and malformed-encoding paths, and the exact length of the timeout.

// File: rtl/cpxfer_pkg.sv
package cpxfer_pkg;

   typedef enum logic [1:0] {
      CYC_SEQ = 2'b00,
      CYC_INT = 2'b01,
      CYC_CPX = 2'b10
   } cyc_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEQ,
      ST_BUSY,
      ST_TAIL,
      ST_XFER,
      ST_END
   } state_e;

   typedef struct packed {
      logic [3:0] cond;
      logic [2:0] opc;
      logic       dir;
      logic [3:0] crn;
      logic [3:0] rd;
      logic [3:0] cpn;
      logic [2:0] typ;
      logic [3:0] crm;
   } fields_t;

endpackage

// File: rtl/cpxfer_cond.sv
module cpxfer_cond #(
   parameter bit NV_PASSES = 1'b0
) (
   input  logic [3:0] cond,
   input  logic [3:0] flags,
   output logic       pass
);
   logic fn, fz, fc, fv, nv_val;

   assign fn = flags[3];
   assign fz = flags[2];
   assign fc = flags[1];
   assign fv = flags[0];

   generate
      if (NV_PASSES) begin : g_nv_always
         assign nv_val = 1'b1;
      end else begin : g_nv_never
         assign nv_val = 1'b0;
      end
   endgenerate

   always_comb begin
      case (cond)
         4'h0: pass = fz;
         4'h1: pass = !fz;
         4'h2: pass = fc;
         4'h3: pass = !fc;
         4'h4: pass = fn;
         4'h5: pass = !fn;
         4'h6: pass = fv;
         4'h7: pass = !fv;
         4'h8: pass = fc && !fz;
         4'h9: pass = !fc || fz;
         4'hA: pass = (fn == fv);
         4'hB: pass = (fn != fv);
         4'hC: pass = !fz && (fn == fv);
         4'hD: pass = fz || (fn != fv);
         4'hE: pass = 1'b1;
         default: pass = nv_val;
      endcase
   end
endmodule

// File: rtl/cpxfer_decode.sv
module cpxfer_decode
   import cpxfer_pkg::*;
(
   input  logic [31:0] instr,
   output fields_t     fields,
   output logic        well_formed
);
   localparam logic [3:0] CLASS_CODE = 4'b1110;

   always_comb begin
      fields.cond = instr[31:28];
      fields.opc  = instr[23:21];
      fields.dir  = instr[20];
      fields.crn  = instr[19:16];
      fields.rd   = instr[15:12];
      fields.cpn  = instr[11:8];
      fields.typ  = instr[7:5];
      fields.crm  = instr[3:0];
      well_formed = (instr[27:24] == CLASS_CODE) && instr[4];
   end
endmodule

// File: rtl/cpxfer_timer.sv
module cpxfer_timer #(
   parameter int TIMEOUT = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic en,
   output logic last
);
   localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
   localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT - 1);

   logic [CW-1:0] cnt;

   initial begin
      if (TIMEOUT < 2) $fatal(1, "cpxfer_timer: TIMEOUT must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst || clr) cnt <= '0;
      else if (en && cnt != LIMIT) cnt <= cnt + 1'b1;
   end

   assign last = (cnt == LIMIT);
endmodule

// File: rtl/cpxfer_fsm.sv
module cpxfer_fsm
   import cpxfer_pkg::*;
#(
   parameter int DW        = 32,
   parameter int PC_OFFSET = 12
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  fields_t       fields,
   input  logic          well_formed,
   input  logic          cond_pass,
   input  logic [DW-1:0] pc_in,
   input  logic          tmr_last,
   output logic          tmr_clr,
   output logic          tmr_en,
   output logic [3:0]    rf_rd_addr,
   input  logic [DW-1:0] rf_rd_data,
   output logic          rf_we,
   output logic [3:0]    rf_wr_addr,
   output logic [DW-1:0] rf_wr_data,
   output logic          flag_we,
   output logic [3:0]    flag_out,
   output logic          cp_req,
   output logic          cp_dir,
   output logic [3:0]    cp_num,
   output logic [2:0]    cp_opc,
   output logic [3:0]    cp_crn,
   output logic [3:0]    cp_crm,
   output logic [2:0]    cp_type,
   output logic [DW-1:0] cp_wdata,
   input  logic          cp_ack,
   input  logic          cp_busy,
   input  logic [DW-1:0] cp_rdata,
   output logic          cyc_valid,
   output logic [1:0]    cyc_type,
   output logic          done,
   output logic          undef
);
   localparam logic [3:0]    PC_REG  = 4'd15;
   localparam logic [DW-1:0] PC_ADD  = DW'(PC_OFFSET);

   state_e        state, state_n;
   fields_t       f_q;
   logic [DW-1:0] pc_q;
   logic          end_undef;
   logic          is_pc;
   logic          active;

   initial begin
      if (DW < 8) $fatal(1, "cpxfer_fsm: DW must be at least 8");
   end

   assign is_pc  = (f_q.rd == PC_REG);
   assign active = (state == ST_SEQ) || (state == ST_BUSY) ||
                   (state == ST_TAIL) || (state == ST_XFER);

   always_comb begin
      state_n = state;
      case (state)
         ST_IDLE: begin
            if (start) state_n = (well_formed && cond_pass) ? ST_SEQ : ST_END;
         end
         ST_SEQ: begin
            if (cp_ack) begin
               if (cp_busy)       state_n = ST_BUSY;
               else if (f_q.dir)  state_n = ST_TAIL;
               else               state_n = ST_XFER;
            end else if (tmr_last) begin
               state_n = ST_END;
            end
         end
         ST_BUSY: begin
            if (!cp_busy) state_n = f_q.dir ? ST_TAIL : ST_XFER;
         end
         ST_TAIL: state_n = ST_XFER;
         ST_XFER: state_n = ST_IDLE;
         ST_END:  state_n = ST_IDLE;
         default: state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ST_IDLE;
         f_q       <= '0;
         pc_q      <= '0;
         end_undef <= 1'b0;
      end else begin
         state <= state_n;
         if (state == ST_IDLE && start) begin
            f_q       <= fields;
            pc_q      <= pc_in;
            end_undef <= !well_formed;
         end else if (state == ST_SEQ && !cp_ack && tmr_last) begin
            end_undef <= 1'b1;
         end
      end
   end

   assign tmr_clr = (state != ST_SEQ);
   assign tmr_en  = (state == ST_SEQ) && !cp_ack;

   always_comb begin
      cyc_valid = active;
      case (state)
         ST_SEQ:           cyc_type = CYC_SEQ;
         ST_BUSY, ST_TAIL: cyc_type = CYC_INT;
         ST_XFER:          cyc_type = CYC_CPX;
         default:          cyc_type = CYC_SEQ;
      endcase
   end

   assign cp_req  = active;
   assign cp_dir  = f_q.dir;
   assign cp_num  = f_q.cpn;
   assign cp_opc  = f_q.opc;
   assign cp_crn  = f_q.crn;
   assign cp_crm  = f_q.crm;
   assign cp_type = f_q.typ;

   assign rf_rd_addr = f_q.rd;
   assign cp_wdata   = (!active || f_q.dir) ? '0 :
                       (is_pc ? (pc_q + PC_ADD) : rf_rd_data);

   assign rf_we      = (state == ST_XFER) && f_q.dir && !is_pc;
   assign rf_wr_addr = f_q.rd;
   assign rf_wr_data = cp_rdata;
   assign flag_we    = (state == ST_XFER) && f_q.dir && is_pc;
   assign flag_out   = cp_rdata[DW-1 -: 4];

   assign done  = (state == ST_XFER) || (state == ST_END);
   assign undef = (state == ST_END) && end_undef;

   // R8: every request opens with a sequential cycle
   a_r8_seq_first: assert property (@(posedge clk) disable iff (rst)
      $rose(cp_req) |-> (cyc_type == CYC_SEQ));

   // R7: the request is released right after the transfer cycle
   a_r7_release_after_xfer: assert property (@(posedge clk) disable iff (rst)
      (cp_req && cyc_type == CYC_CPX) |=> !cp_req);

   // R7: a coprocessor-to-core transfer always follows an internal cycle
   a_r7_tail_before_xfer: assert property (@(posedge clk) disable iff (rst)
      (cp_req && cp_dir && cyc_type == CYC_CPX) |-> ($past(cyc_type) == CYC_INT));

   // R4: register and flag writes never coincide
   a_r4_single_target: assert property (@(posedge clk) disable iff (rst)
      !(rf_we && flag_we));

   // R9: undefined outcome carries no write and no request
   a_r9_undef_quiet: assert property (@(posedge clk) disable iff (rst)
      undef |-> (!rf_we && !flag_we && !cp_req));

   // R1: request fields hold while the request stays up
   a_r1_fields_stable: assert property (@(posedge clk) disable iff (rst)
      (cp_req && $past(cp_req)) |-> ($stable(cp_num) && $stable(cp_opc) &&
      $stable(cp_crn) && $stable(cp_crm) && $stable(cp_type) && $stable(cp_dir)));

   // R11: outputs are quiet in the cycle after reset
   logic rst_q;
   always_ff @(posedge clk) rst_q <= rst;
   always_ff @(posedge clk) begin
      if (rst_q && !rst) begin
         a_r11_quiet_after_reset: assert (!cp_req && !rf_we && !flag_we && !undef);
      end
   end
endmodule

// File: rtl/cpxfer_seq.sv
module cpxfer_seq
   import cpxfer_pkg::*;
#(
   parameter int DW        = 32,
   parameter int PC_OFFSET = 12,
   parameter int TIMEOUT   = 16,
   parameter bit NV_PASSES = 1'b0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic [31:0]   instr,
   input  logic [3:0]    flags_in,
   input  logic [DW-1:0] pc_in,
   output logic [3:0]    rf_rd_addr,
   input  logic [DW-1:0] rf_rd_data,
   output logic          rf_we,
   output logic [3:0]    rf_wr_addr,
   output logic [DW-1:0] rf_wr_data,
   output logic          flag_we,
   output logic [3:0]    flag_out,
   output logic          cp_req,
   output logic          cp_dir,
   output logic [3:0]    cp_num,
   output logic [2:0]    cp_opc,
   output logic [3:0]    cp_crn,
   output logic [3:0]    cp_crm,
   output logic [2:0]    cp_type,
   output logic [DW-1:0] cp_wdata,
   input  logic          cp_ack,
   input  logic          cp_busy,
   input  logic [DW-1:0] cp_rdata,
   output logic          cyc_valid,
   output logic [1:0]    cyc_type,
   output logic          done,
   output logic          undef
);
   fields_t fields;
   logic    well_formed;
   logic    cond_pass;
   logic    tmr_clr, tmr_en, tmr_last;

   cpxfer_decode u_decode (
      .instr       (instr),
      .fields      (fields),
      .well_formed (well_formed)
   );

   cpxfer_cond #(.NV_PASSES(NV_PASSES)) u_cond (
      .cond  (fields.cond),
      .flags (flags_in),
      .pass  (cond_pass)
   );

   cpxfer_timer #(.TIMEOUT(TIMEOUT)) u_timer (
      .clk  (clk),
      .rst  (rst),
      .clr  (tmr_clr),
      .en   (tmr_en),
      .last (tmr_last)
   );

   cpxfer_fsm #(.DW(DW), .PC_OFFSET(PC_OFFSET)) u_fsm (
      .clk         (clk),
      .rst         (rst),
      .start       (start),
      .fields      (fields),
      .well_formed (well_formed),
      .cond_pass   (cond_pass),
      .pc_in       (pc_in),
      .tmr_last    (tmr_last),
      .tmr_clr     (tmr_clr),
      .tmr_en      (tmr_en),
      .rf_rd_addr  (rf_rd_addr),
      .rf_rd_data  (rf_rd_data),
      .rf_we       (rf_we),
      .rf_wr_addr  (rf_wr_addr),
      .rf_wr_data  (rf_wr_data),
      .flag_we     (flag_we),
      .flag_out    (flag_out),
      .cp_req      (cp_req),
      .cp_dir      (cp_dir),
      .cp_num      (cp_num),
      .cp_opc      (cp_opc),
      .cp_crn      (cp_crn),
      .cp_crm      (cp_crm),
      .cp_type     (cp_type),
      .cp_wdata    (cp_wdata),
      .cp_ack      (cp_ack),
      .cp_busy     (cp_busy),
      .cp_rdata    (cp_rdata),
      .cyc_valid   (cyc_valid),
      .cyc_type    (cyc_type),
      .done        (done),
      .undef       (undef)
   );
endmodule

// File: tb/cpxfer_seq_tb.sv
module cpxfer_seq_tb;
   localparam int TO = 16;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [31:0] instr = '0;
   logic [3:0]  flags_in = '0;
   logic [31:0] pc_in = '0;
   logic [3:0]  rf_rd_addr;
   logic [31:0] rf_rd_data;
   logic        rf_we;
   logic [3:0]  rf_wr_addr;
   logic [31:0] rf_wr_data;
   logic        flag_we;
   logic [3:0]  flag_out;
   logic        cp_req, cp_dir;
   logic [3:0]  cp_num, cp_crn, cp_crm;
   logic [2:0]  cp_opc, cp_type;
   logic [31:0] cp_wdata;
   logic        cp_ack, cp_busy;
   logic [31:0] cp_rdata = '0;
   logic        cyc_valid;
   logic [1:0]  cyc_type;
   logic        done, undef;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   int          busy_len = 0;
   logic [3:0]  dead_cp = 4'hF;
   int          req_idx = 0;

   always #10 clk = ~clk;

   assign rf_rd_data = 32'hA000_0000 | {28'd0, rf_rd_addr};

   always_ff @(posedge clk) begin
      if (!cp_req) req_idx <= 0;
      else         req_idx <= req_idx + 1;
   end
   assign cp_ack  = cp_req && (cp_num != dead_cp);
   assign cp_busy = cp_req && (req_idx < busy_len);

   cpxfer_seq #(.TIMEOUT(TO)) u_dut (
      .clk(clk), .rst(rst), .start(start), .instr(instr), .flags_in(flags_in),
      .pc_in(pc_in), .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
      .rf_we(rf_we), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data),
      .flag_we(flag_we), .flag_out(flag_out), .cp_req(cp_req), .cp_dir(cp_dir),
      .cp_num(cp_num), .cp_opc(cp_opc), .cp_crn(cp_crn), .cp_crm(cp_crm),
      .cp_type(cp_type), .cp_wdata(cp_wdata), .cp_ack(cp_ack), .cp_busy(cp_busy),
      .cp_rdata(cp_rdata), .cyc_valid(cyc_valid), .cyc_type(cyc_type),
      .done(done), .undef(undef)
   );

   // observations of the last instruction
   int          n_s, n_i, n_c, n_req, n_rfw, n_flw, n_undef, n_bad;
   logic [3:0]  o_waddr, o_flags, o_num, o_crn, o_crm, o_raddr;
   logic [2:0]  o_opc, o_typ;
   logic        o_dir;
   logic [31:0] o_wdata, o_xdata;
   bit          o_done;

   function automatic logic [31:0] mk(input logic [3:0] c, input logic [2:0] op,
                                      input logic l, input logic [3:0] crn,
                                      input logic [3:0] rd, input logic [3:0] cpn,
                                      input logic [2:0] ty, input logic [3:0] crm);
      return {c, 4'b1110, op, l, crn, rd, cpn, ty, 1'b1, crm};
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run(input logic [31:0] ins, input logic [3:0] flg,
                      input logic [31:0] pc, input int b, input logic [31:0] rdata);
      n_s = 0; n_i = 0; n_c = 0; n_req = 0; n_rfw = 0; n_flw = 0; n_undef = 0; n_bad = 0;
      o_done = 0; o_wdata = '0; o_xdata = '0; o_waddr = '0; o_flags = '0;
      busy_len = b; cp_rdata = rdata;
      @(negedge clk);
      instr = ins; flags_in = flg; pc_in = pc; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 200; k++) begin
         if (cyc_valid) begin
            if (cyc_type == 2'b00) n_s++;
            else if (cyc_type == 2'b01) n_i++;
            else if (cyc_type == 2'b10) begin
               n_c++; o_xdata = cp_wdata;
            end else n_bad++;
         end
         if (cp_req) begin
            if (n_req == 0) begin
               o_num = cp_num; o_opc = cp_opc; o_crn = cp_crn; o_crm = cp_crm;
               o_typ = cp_type; o_dir = cp_dir; o_raddr = rf_rd_addr;
            end
            n_req++;
         end
         if (rf_we) begin n_rfw++; o_waddr = rf_wr_addr; o_wdata = rf_wr_data; end
         if (flag_we) begin n_flw++; o_flags = flag_out; end
         if (undef) n_undef++;
         if (done) begin o_done = 1; break; end
         @(negedge clk);
      end
      chk("done reached", 64'(o_done), 64'd1);
   endtask

   task automatic t_reset();
      chk("R11 cp_req", 64'(cp_req), 0);
      chk("R11 rf_we", 64'(rf_we), 0);
      chk("R11 flag_we", 64'(flag_we), 0);
      chk("R11 done/undef", 64'({done, undef}), 0);
      chk("R11 cyc_valid", 64'(cyc_valid), 0);
   endtask

   task automatic t_mrc_reg();
      run(mk(4'hE, 3'd5, 1'b1, 4'd5, 4'd3, 4'd2, 3'd2, 4'd6), 4'h0, 32'h0, 3, 32'h1234_5678);
      chk("R1 cp_num", 64'(o_num), 2);
      chk("R1 cp_opc", 64'(o_opc), 5);
      chk("R1 cp_crn/crm", 64'({o_crn, o_crm}), 8'h56);
      chk("R1 cp_type/dir", 64'({o_typ, o_dir}), {3'd2, 1'b1});
      chk("R7 seq count", 64'(n_s), 1);
      chk("R7 internal count b=3", 64'(n_i), 4);
      chk("R7 transfer count", 64'(n_c), 1);
      chk("R7 bad cycle codes", 64'(n_bad), 0);
      chk("R3 write count", 64'(n_rfw), 1);
      chk("R3 write addr", 64'(o_waddr), 3);
      chk("R3 write data", 64'(o_wdata), 32'h1234_5678);
      chk("R3 no flag write", 64'(n_flw), 0);
   endtask

   task automatic t_mrc_pc();
      run(mk(4'hE, 3'd0, 1'b1, 4'd1, 4'd15, 4'd3, 3'd0, 4'd2), 4'h0, 32'h0, 0, 32'hA5FF_FFFF);
      chk("R4 flag write count", 64'(n_flw), 1);
      chk("R4 flag value", 64'(o_flags), 4'hA);
      chk("R4 no reg write", 64'(n_rfw), 0);
      chk("R7 internal count b=0", 64'(n_i), 1);
   endtask

   task automatic t_mcr_reg();
      run(mk(4'hE, 3'd0, 1'b0, 4'd5, 4'd4, 4'd6, 3'd1, 4'd6), 4'h0, 32'h0, 2, 32'h0);
      chk("R8 seq count", 64'(n_s), 1);
      chk("R8 internal count b=2", 64'(n_i), 2);
      chk("R8 transfer count", 64'(n_c), 1);
      chk("R5 read addr", 64'(o_raddr), 4);
      chk("R5 data out", 64'(o_xdata), 32'hA000_0004);
      chk("R5 no writes", 64'(n_rfw + n_flw), 0);
   endtask

   task automatic t_mcr_pc();
      run(mk(4'hE, 3'd1, 1'b0, 4'd2, 4'd15, 4'd7, 3'd0, 4'd0), 4'h0, 32'h0000_1000, 0, 32'h0);
      chk("R6 pc plus 12", 64'(o_xdata), 32'h0000_100C);
      chk("R8 internal count b=0", 64'(n_i), 0);
      chk("R6 no writes", 64'(n_rfw + n_flw), 0);
   endtask

   task automatic t_cond();
      run(mk(4'h0, 3'd0, 1'b1, 4'd1, 4'd2, 4'd3, 3'd0, 4'd1), 4'b0000, 32'h0, 0, 32'hFFFF_FFFF);
      chk("R2 no request on fail", 64'(n_req), 0);
      chk("R2 no writes on fail", 64'(n_rfw + n_flw), 0);
      chk("R2 undef low on fail", 64'(n_undef), 0);
      run(mk(4'h0, 3'd0, 1'b1, 4'd1, 4'd2, 4'd3, 3'd0, 4'd1), 4'b0100, 32'h0, 0, 32'h0000_0077);
      chk("R2 request when Z set", 64'(n_req > 0), 1);
      chk("R2 write when Z set", 64'(n_rfw), 1);
   endtask

   task automatic t_malformed();
      logic [31:0] w;
      w = mk(4'hE, 3'd0, 1'b1, 4'd1, 4'd2, 4'd3, 3'd0, 4'd1);
      w[4] = 1'b0;
      run(w, 4'h0, 32'h0, 0, 32'h0);
      chk("R10 undef on bit4 low", 64'(n_undef), 1);
      chk("R10 no request", 64'(n_req), 0);
      w = mk(4'hE, 3'd0, 1'b1, 4'd1, 4'd2, 4'd3, 3'd0, 4'd1);
      w[27:24] = 4'b1100;
      run(w, 4'h0, 32'h0, 0, 32'h0);
      chk("R10 undef on class bits", 64'(n_undef), 1);
      chk("R10 no writes", 64'(n_rfw + n_flw), 0);
   endtask

   task automatic t_timeout();
      run(mk(4'hE, 3'd0, 1'b1, 4'd1, 4'd2, 4'hF, 3'd0, 4'd1), 4'h0, 32'h0, 0, 32'h0);
      chk("R9 sequential cycles before undef", 64'(n_s), TO);
      chk("R9 undef raised", 64'(n_undef), 1);
      chk("R9 no writes", 64'(n_rfw + n_flw), 0);
      chk("R9 no transfer cycle", 64'(n_c), 0);
   endtask

   task automatic finish_up();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk("watchdog expired", 64'd1, 64'd0);
      finish_up();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_mrc_reg();
      t_mrc_pc();
      t_mcr_reg();
      t_mcr_pc();
      t_cond();
      t_malformed();
      t_timeout();
      repeat (2) @(negedge clk);
      finish_up();
   end
endmodule